// File: doc/BRIEF.md
# Open-Drain Line Direction Arbiter

This block joins two open-drain data lines, one on the host side and one on the card side, which both rest high through pull-ups. Neither side is told the direction in advance. The first side that pulls its line low becomes the master. After a fixed delay, the block copies that low onto the other side, which is the slave. When the master lets its line go high again, the block drives a short active pull-up pulse on the slave side so that the rising edge is fast. It then releases both sides and waits for the next falling edge.

Each side gives the block a raw line level. The block passes each level through a synchronizer and looks for falling edges. For each side it produces two outputs: one enables a pull-down and one enables an active pull-up. While a transfer is in progress, edge detection on both sides is switched off. This stops the low that the block itself forces onto the slave from being read as a second master. One instance serves each data or auxiliary contact pair of a card reader front end. The analog drivers and level shifting are outside the block.

Top module: `od_line_arbiter`

## Requirements
- R1: Out of reset and while no transfer is in progress, all four drive enables (hostDrvLow, hostPullUp, cardDrvLow, cardPullUp) are 0.
- R2: When hostIn falls, the slave's cardDrvLow rises on rising edge SYNC_STAGES+EDGE_DLY+1. Edges are counted from the first edge that samples hostIn low, which is edge 1. cardDrvLow stays high while hostIn stays low.
- R3: The same as R2 with the sides swapped: when cardIn falls first, hostDrvLow follows with the same timing.
- R4: If both lines are first sampled low on the same edge, the host side becomes the master and only the card side is driven.
- R5: The master side's own enables stay 0 for the whole transfer. The slave line, pulled low by the block, never takes over as master.
- R6: When the master line is released after the slave has been driven, the slave drive-low drops on rising edge SYNC_STAGES+1, counted from the first edge that samples the master high. On that same edge the slave pull-up enable rises and stays high for exactly PU_LEN cycles.
- R7: After the pull-up pulse both sides are released and idle. A new falling edge on either side then starts a fresh transfer with the same timing.
- R8: If the master releases its line within EDGE_DLY edges of the first low sample, neither side is ever driven and the block returns to idle.
- R9: On each side, drive-low and pull-up are never enabled together, and at most one side has any enable active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostIn | input | 1 | Raw level of the host-side line |
| cardIn | input | 1 | Raw level of the card-side line |
| hostDrvLow | output | 1 | Enable for the host-side pull-down |
| hostPullUp | output | 1 | Enable for the host-side active pull-up |
| cardDrvLow | output | 1 | Enable for the card-side pull-down |
| cardPullUp | output | 1 | Enable for the card-side active pull-up |

## Verification
The bench models both lines as real open-drain wires: the block's own pull-down feeds back into its input, so the masking of the slave's repeated low is tested under the conditions that matter. Random transfers choose host or card as master and choose a low duration. Durations shorter than or equal to the edge delay separate the abort path from the normal copy path. Longer durations place the release at different points and so pin down the exact length of the pull-up pulse. A run of transfers in which both sides fall on the same cycle isolates the host-first tie-break. Back-to-back transfers with no idle gap show that the block truly returns to idle after each pulse.

// File: rtl/od_arb_pkg.sv
package od_arb_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_WAIT  = 2'd1,
    ARB_HOLD  = 2'd2,
    ARB_BOOST = 2'd3
  } arbState_t;

  // Strobes from control to the datapath
  typedef struct packed {
    logic armEdges;
    logic loadDly;
    logic loadPu;
    logic cntEn;
  } arbStrobe_t;

  // Status from the datapath back to control
  typedef struct packed {
    logic hostFall;
    logic cardFall;
    logic hostLvl;
    logic cardLvl;
    logic cntZero;
  } arbStatus_t;

endpackage

// File: rtl/od_arb_datapath.sv
module od_arb_datapath
  import od_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EDGE_DLY    = 4,
  parameter int PU_LEN      = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostIn,
  input  logic       cardIn,
  input  arbStrobe_t strobe,
  output arbStatus_t status
);

  localparam int CNT_MAX = (EDGE_DLY > PU_LEN) ? EDGE_DLY : PU_LEN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int SIDES   = 2;

  logic [SIDES-1:0] rawIn;
  logic [SIDES-1:0] lvl;
  logic [SIDES-1:0] prevLvl;
  logic [SIDES-1:0] fall;
  logic [CNT_W-1:0] cnt;

  assign rawIn = {cardIn, hostIn};

  // One synchronizer and edge detector per side
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic [SYNC_STAGES-1:0] syncQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ      <= '1;
        prevLvl[s] <= 1'b1;
      end else begin
        syncQ      <= {syncQ[SYNC_STAGES-2:0], rawIn[s]};
        prevLvl[s] <= syncQ[SYNC_STAGES-1];
      end
    end
    assign lvl[s]  = syncQ[SYNC_STAGES-1];
    assign fall[s] = strobe.armEdges & prevLvl[s] & ~lvl[s];
  end

  // Shared down-counter for the edge delay and the pull-up pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.loadDly) cnt <= CNT_W'(EDGE_DLY - 1);
    else if (strobe.loadPu)  cnt <= CNT_W'(PU_LEN - 1);
    else if (strobe.cntEn)   cnt <= cnt - 1'b1;
  end

  assign status.hostFall = fall[0];
  assign status.cardFall = fall[1];
  assign status.hostLvl  = lvl[0];
  assign status.cardLvl  = lvl[1];
  assign status.cntZero  = (cnt == '0);

endmodule

// File: rtl/od_arb_control.sv
module od_arb_control
  import od_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  arbStatus_t status,
  output arbStrobe_t strobe,
  output logic       hostDrvLow,
  output logic       hostPullUp,
  output logic       cardDrvLow,
  output logic       cardPullUp
);

  arbState_t state, stateNxt;
  logic      masterHost, masterHostNxt;
  logic      masterLvl;

  assign masterLvl = masterHost ? status.hostLvl : status.cardLvl;

  always_comb begin
    stateNxt      = state;
    masterHostNxt = masterHost;
    strobe        = '0;
    case (state)
      ARB_IDLE: begin
        strobe.armEdges = 1'b1;
        if (status.hostFall) begin
          masterHostNxt  = 1'b1;
          strobe.loadDly = 1'b1;
          stateNxt       = ARB_WAIT;
        end else if (status.cardFall) begin
          masterHostNxt  = 1'b0;
          strobe.loadDly = 1'b1;
          stateNxt       = ARB_WAIT;
        end
      end
      ARB_WAIT: begin
        if (masterLvl)           stateNxt = ARB_IDLE;
        else if (status.cntZero) stateNxt = ARB_HOLD;
        else                     strobe.cntEn = 1'b1;
      end
      ARB_HOLD: begin
        if (masterLvl) begin
          strobe.loadPu = 1'b1;
          stateNxt      = ARB_BOOST;
        end
      end
      ARB_BOOST: begin
        if (status.cntZero) stateNxt = ARB_IDLE;
        else                strobe.cntEn = 1'b1;
      end
      default: stateNxt = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ARB_IDLE;
      masterHost <= 1'b1;
    end else begin
      state      <= stateNxt;
      masterHost <= masterHostNxt;
    end
  end

  assign cardDrvLow = (state == ARB_HOLD)  &&  masterHost;
  assign cardPullUp = (state == ARB_BOOST) &&  masterHost;
  assign hostDrvLow = (state == ARB_HOLD)  && !masterHost;
  assign hostPullUp = (state == ARB_BOOST) && !masterHost;

endmodule

// File: rtl/od_line_arbiter.sv
module od_line_arbiter
  import od_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EDGE_DLY    = 4,
  parameter int PU_LEN      = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostIn,
  input  logic cardIn,
  output logic hostDrvLow,
  output logic hostPullUp,
  output logic cardDrvLow,
  output logic cardPullUp
);

  arbStrobe_t strobe;
  arbStatus_t status;

  od_arb_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .EDGE_DLY   (EDGE_DLY),
    .PU_LEN     (PU_LEN)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .hostIn(hostIn),
    .cardIn(cardIn),
    .strobe(strobe),
    .status(status)
  );

  od_arb_control ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .status    (status),
    .strobe    (strobe),
    .hostDrvLow(hostDrvLow),
    .hostPullUp(hostPullUp),
    .cardDrvLow(cardDrvLow),
    .cardPullUp(cardPullUp)
  );

endmodule

// File: rtl/od_line_arbiter_chk.sv
module od_line_arbiter_chk #(
  parameter int PU_LEN = 3
) (
  input logic clk,
  input logic rstN,
  input logic hostDrvLow,
  input logic hostPullUp,
  input logic cardDrvLow,
  input logic cardPullUp
);

  localparam int RUN_W = $clog2(PU_LEN + 2);

  logic             anyPu;
  logic [RUN_W-1:0] puRun;

  assign anyPu = hostPullUp | cardPullUp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      puRun <= '0;
    else if (anyPu) puRun <= puRun + 1'b1;
    else            puRun <= '0;
  end

  // R9
  host_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hostDrvLow && hostPullUp));

  // R9
  card_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cardDrvLow && cardPullUp));

  // R5
  one_side_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hostDrvLow | hostPullUp, cardDrvLow | cardPullUp}));

  // R6
  pu_after_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardPullUp) |-> $past(cardDrvLow));

  // R6
  pu_max_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyPu |-> (int'(puRun) < PU_LEN));

  // R6
  pu_exact_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(anyPu) |-> (int'($past(puRun)) == PU_LEN - 1));

  // R7
  idle_after_pu_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(anyPu) |-> !(hostDrvLow || cardDrvLow || anyPu));

endmodule

bind od_line_arbiter od_line_arbiter_chk #(.PU_LEN(PU_LEN)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .hostDrvLow(hostDrvLow),
  .hostPullUp(hostPullUp),
  .cardDrvLow(cardDrvLow),
  .cardPullUp(cardPullUp)
);

// File: tb/od_line_arbiter_tb_top.sv
`timescale 1ns/1ps
module od_line_arbiter_tb_top;

  localparam int S  = 2;
  localparam int E  = 5;
  localparam int PU = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostDrv = 1'b1;
  logic cardDrv = 1'b1;
  logic hostDrvLow, hostPullUp, cardDrvLow, cardPullUp;
  logic hostLine, cardLine;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  // Open-drain wires: the block's pull-down feeds back into its own input
  assign hostLine = hostDrv & ~hostDrvLow;
  assign cardLine = cardDrv & ~cardDrvLow;

  od_line_arbiter #(.SYNC_STAGES(S), .EDGE_DLY(E), .PU_LEN(PU)) dut_i (
    .clk(clk), .rstN(rstN), .hostIn(hostLine), .cardIn(cardLine),
    .hostDrvLow(hostDrvLow), .hostPullUp(hostPullUp),
    .cardDrvLow(cardDrvLow), .cardPullUp(cardPullUp)
  );

  function automatic logic [3:0] outs();
    return {hostDrvLow, hostPullUp, cardDrvLow, cardPullUp};
  endfunction

  // Expected {drv,pu} of the slave after edge n, master low for L edges
  function automatic logic [1:0] expSlave(int n, int L);
    bit drove = (L > E);
    logic drv = drove && (n >= S + E + 1) && (n < L + S + 1);
    logic pu  = drove && (n >= L + S + 1) && (n < L + S + 1 + PU);
    return {drv, pu};
  endfunction

  task automatic chk(bit ok, string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idleCycles(int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk); @(negedge clk);
      chk(outs() == 4'b0000, "R1", outs(), 4'b0000);
    end
  endtask

  // One transfer: master low for L edges; tie drives both sides low
  task automatic txn(bit hostMaster, int L, bit tie);
    bit mh = hostMaster | tie;
    int endN = L + S + 1 + PU + 1;
    if (mh || tie) hostDrv = 1'b0;
    if (!mh || tie) cardDrv = 1'b0;
    for (int n = 1; n <= endN; n++) begin
      logic [1:0] sl;
      logic [3:0] exp;
      string tag;
      @(posedge clk); @(negedge clk);
      sl  = expSlave(n, L);
      exp = mh ? {2'b00, sl} : {sl, 2'b00};
      if (L <= E)            tag = "R8";
      else if (sl[0])        tag = "R6";
      else if (n >= L+S+1)   tag = "R7";
      else if (tie)          tag = "R4";
      else                   tag = mh ? "R2" : "R3";
      chk(outs() == exp, tag, outs(), exp);
      chk(mh ? (outs()[3:2] == 2'b00) : (outs()[1:0] == 2'b00), "R5", outs(), exp);
      chk(!(hostDrvLow && hostPullUp) && !(cardDrvLow && cardPullUp), "R9", outs(), exp);
      if (n == L) begin
        hostDrv = 1'b1;
        cardDrv = 1'b1;
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge clk);
    chk(outs() == 4'b0000, "R1", outs(), 4'b0000);
    rstN = 1'b1;
    idleCycles(4);
    // Directed corners
    txn(1'b1, E + 4, 1'b0);   // R2 host master
    txn(1'b0, E + 4, 1'b0);   // R3 card master, back to back (R7)
    idleCycles(2);
    txn(1'b1, E, 1'b0);       // R8 release at the limit
    idleCycles(2);
    txn(1'b0, E + 1, 1'b0);   // single-cycle hold edge case
    idleCycles(2);
    txn(1'b0, E + 6, 1'b1);   // R4 tie
    idleCycles(1);
    txn(1'b1, 1, 1'b0);       // R8 glitch-short low
    // Random mix
    for (int t = 0; t < 60; t++) begin
      bit hm  = $urandom_range(1, 0) == 1;
      bit tie = $urandom_range(5, 0) == 0;
      int L   = $urandom_range(E + 12, 1);
      txn(hm, L, tie);
      idleCycles($urandom_range(3, 0));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule